// File: doc/BRIEF.md
# External Interrupt Request Controller

This block is a per-processor external interrupt unit. It holds a pending-request register and an enable-mask register, both `W` bits wide. Any agent on the system bus, such as an I/O controller or another processor raising an inter-processor interrupt, posts a request by writing an interrupt number into one mapped word. The block decodes that number into a single pending bit. Bit numbering is big-endian: interrupt number 0 selects the most significant bit.

On the processor side, a control-register port reads either register. Writing the pending register clears every bit written as one. Writing the mask register replaces the whole mask.

The block drives one level-sensitive, registered interrupt line to the core. The line is high while any pending bit is also enabled in the mask.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset the pending register, the mask register and `irq` are all zero.
- R2: A valid bus write (`bus_size` = 2, meaning 4 bytes) sets pending bit `W-1-n`, where `n` is the low `log2(W)` bits of `bus_wdata`. Number 0 sets the most significant bit and number `W-1` sets bit 0.
- R3: A bus write only ORs one bit into the pending register. Bits already pending stay set, and data bits above the low `log2(W)` bits have no effect on which bit is set.
- R4: Every bus access gets `bus_resp_valid` one cycle later. A valid read returns the pending register as it was in the cycle of the request, with `bus_resp_err` low. Writes and errored accesses return zero data.
- R5: A bus access with `bus_size` other than 2 (0 = 1 byte, 1 = 2 bytes, 3 = 8 bytes) answers with `bus_resp_err` high and leaves both registers unchanged.
- R6: A processor write with `cr_sel` = 0 clears each pending bit that is 1 in `cr_wdata` and leaves the other pending bits unchanged.
- R7: A processor write with `cr_sel` = 1 loads `cr_wdata` into the mask register.
- R8: `irq` equals the OR-reduction of (pending AND mask) as it stood one cycle earlier, so it follows any register change with one cycle of delay.
- R9: When a bus write sets a bit in the same cycle that a processor clear targets that bit, the bit ends up set.
- R10: `cr_rdata` shows the pending register when `cr_sel` = 0 and the mask register when `cr_sel` = 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes |
| bus_wdata | input | W | Bus write data; the low log2(W) bits carry the interrupt number |
| bus_resp_valid | output | 1 | Response strobe, one cycle after the request |
| bus_resp_err | output | 1 | Response is an access-size error |
| bus_rdata | output | W | Read data for the response |
| cr_wr | input | 1 | Processor control-register write |
| cr_sel | input | 1 | Register select: 0 = pending, 1 = mask |
| cr_wdata | input | W | Processor write data |
| cr_rdata | output | W | Selected register contents |
| irq | output | 1 | Level interrupt request to the core |

## Verification
A wrong bit in the pending register is visible on `cr_rdata` in the same cycle it exists. It also reaches `irq` one cycle later whenever that bit is enabled in the mask. A corrupted mask shows on `cr_rdata` at once, and it shows on `irq` one cycle after a matching request arrives. The bench's reference model advances with the design every clock and compares `irq`, the bus response and the selected register read each cycle, so any divergence is reported in the cycle after the faulty edge.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   typedef enum logic {
      CR_PEND = 1'b0,
      CR_MASK = 1'b1
   } cr_sel_e;

   localparam acc_size_e LEGAL_SIZE = SZ_WORD;

endpackage

// File: rtl/eirq_bus_port.sv
module eirq_bus_port
   import eirq_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_valid,
   input  logic         bus_write,
   input  logic [1:0]   bus_size,
   input  logic [W-1:0] bus_wdata,
   input  logic [W-1:0] pend_q,
   output logic [W-1:0] set_vec,
   output logic         resp_valid,
   output logic         resp_err,
   output logic [W-1:0] resp_rdata
);
   localparam int IW = $clog2(W);

   logic          size_ok;
   logic          wr_ok;
   logic          rd_ok;
   logic [IW-1:0] num;

   assign size_ok = (acc_size_e'(bus_size) == LEGAL_SIZE);
   assign wr_ok   = bus_valid && bus_write && size_ok;
   assign rd_ok   = bus_valid && !bus_write && size_ok;
   assign num     = bus_wdata[IW-1:0];

   for (genvar b = 0; b < W; b++) begin : g_dec
      localparam logic [IW-1:0] NUM_B = IW'(W - 1 - b);
      assign set_vec[b] = wr_ok && (num == NUM_B);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= '0;
      end else begin
         resp_valid <= bus_valid;
         resp_err   <= bus_valid && !size_ok;
         resp_rdata <= rd_ok ? pend_q : '0;
      end
   end

   // R4: every request is answered on the following cycle
   assert_resp_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |=> resp_valid);

   // R5: an illegal size always produces an error response
   assert_bad_size_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !size_ok) |=> (resp_valid && resp_err));

endmodule

// File: rtl/eirq_pend_reg.sv
module eirq_pend_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic         clr_en,
   input  logic [W-1:0] clr_data,
   output logic [W-1:0] pend_q
);
   logic [W-1:0] clr_vec;

   assign clr_vec = clr_en ? clr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

   // R3: without a processor clear no pending bit is ever dropped
   assert_no_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_en |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

   // R9: a bus set lands even when a clear hits the same bit
   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/eirq_mask_reg.sv
module eirq_mask_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_en,
   input  logic [W-1:0] ld_data,
   output logic [W-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_q <= '0;
      else if (ld_en) mask_q <= ld_data;
   end

   // R7: a load replaces the whole mask
   assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (mask_q == $past(ld_data)));

endmodule

// File: rtl/eirq_line.sv
module eirq_line #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pend_q,
   input  logic [W-1:0] mask_q,
   output logic         irq
);
   logic active;

   if (W == 64) begin : g_split
      logic lo_hit;
      logic hi_hit;
      assign lo_hit = |(pend_q[31:0]  & mask_q[31:0]);
      assign hi_hit = |(pend_q[63:32] & mask_q[63:32]);
      assign active = lo_hit | hi_hit;
   end else begin : g_flat
      assign active = |(pend_q & mask_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= active;
   end

endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
   import eirq_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_valid,
   input  logic         bus_write,
   input  logic [1:0]   bus_size,
   input  logic [W-1:0] bus_wdata,
   output logic         bus_resp_valid,
   output logic         bus_resp_err,
   output logic [W-1:0] bus_rdata,
   input  logic         cr_wr,
   input  logic         cr_sel,
   input  logic [W-1:0] cr_wdata,
   output logic [W-1:0] cr_rdata,
   output logic         irq
);
   if (!(W == 32 || W == 64)) begin : g_bad_width
      $error("eirq_ctrl: W must be 32 or 64");
   end

   logic [W-1:0] pend_q;
   logic [W-1:0] mask_q;
   logic [W-1:0] set_vec;
   logic         clr_en;
   logic         ld_en;

   assign clr_en = cr_wr && (cr_sel_e'(cr_sel) == CR_PEND);
   assign ld_en  = cr_wr && (cr_sel_e'(cr_sel) == CR_MASK);

   eirq_bus_port #(.W(W)) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_valid  (bus_valid),
      .bus_write  (bus_write),
      .bus_size   (bus_size),
      .bus_wdata  (bus_wdata),
      .pend_q     (pend_q),
      .set_vec    (set_vec),
      .resp_valid (bus_resp_valid),
      .resp_err   (bus_resp_err),
      .resp_rdata (bus_rdata)
   );

   eirq_pend_reg #(.W(W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_en   (clr_en),
      .clr_data (cr_wdata),
      .pend_q   (pend_q)
   );

   eirq_mask_reg #(.W(W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_data (cr_wdata),
      .mask_q  (mask_q)
   );

   eirq_line #(.W(W)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_q (pend_q),
      .mask_q (mask_q),
      .irq    (irq)
   );

   assign cr_rdata = (cr_sel_e'(cr_sel) == CR_MASK) ? mask_q : pend_q;

   // R8: the line tracks the enabled-pending state of the previous cycle
   assert_irq_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == |($past(pend_q) & $past(mask_q))));

   // R5: a badly sized access with no processor write changes nothing
   assert_bad_size_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && (acc_size_e'(bus_size) != LEGAL_SIZE) && !cr_wr)
         |=> ($stable(pend_q) && $stable(mask_q)));

endmodule

// File: tb/sim_eirq_ctrl.sv
module sim_eirq_ctrl;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bv = 1'b0, bw = 1'b0;
   logic [1:0]   bs = 2'd2;
   logic [W-1:0] bd = '0;
   logic         cw = 1'b0, cs = 1'b0;
   logic [W-1:0] cd = '0;
   logic         rv, rerr, irq;
   logic [W-1:0] rd, crd;

   int vectors = 0;
   int fails = 0;

   always #4 clk = ~clk;

   eirq_ctrl #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bv), .bus_write(bw), .bus_size(bs), .bus_wdata(bd),
      .bus_resp_valid(rv), .bus_resp_err(rerr), .bus_rdata(rd),
      .cr_wr(cw), .cr_sel(cs), .cr_wdata(cd), .cr_rdata(crd), .irq(irq)
   );

   // behavioural reference model
   logic [W-1:0] m_pend, m_mask, m_rd, m_set, m_clr;
   logic         m_irq, m_rv, m_err;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend = '0; m_mask = '0; m_irq = 0; m_rv = 0; m_err = 0; m_rd = '0;
      end else begin
         m_set = '0;
         if (bv && bw && bs == 2'd2) m_set[W-1-(bd % W)] = 1'b1;
         m_clr = (cw && !cs) ? cd : '0;
         m_irq = |(m_pend & m_mask);
         m_rv  = bv;
         m_err = bv && (bs != 2'd2);
         m_rd  = (bv && !bw && bs == 2'd2) ? m_pend : '0;
         m_pend = (m_pend & ~m_clr) | m_set;
         if (cw && cs) m_mask = cd;
      end
   end

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // cycle-by-cycle compare, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R8 irq", W'(irq), W'(m_irq));
         chk("R4 resp_valid", W'(rv), W'(m_rv));
         chk("R5 resp_err", W'(rerr), W'(m_err));
         chk("R4 rdata", rd, m_rd);
         chk("R10 cr_rdata", crd, cs ? m_mask : m_pend);
      end
   end

   task automatic drive(logic v, logic w, logic [1:0] s, logic [W-1:0] d,
                        logic c, logic sel, logic [W-1:0] cdat);
      @(posedge clk);
      #2;
      bv = v; bw = w; bs = s; bd = d; cw = c; cs = sel; cd = cdat;
   endtask

   task automatic idle(logic sel);
      drive(0, 0, 2'd2, '0, 0, sel, '0);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pend", crd, '0);
      chk("R1 irq", W'(irq), '0);
      idle(1); @(negedge clk);
      chk("R1 mask", crd, '0);
      // R2: number 0 -> MSB, number 31 -> bit 0
      drive(1, 1, 2'd2, 32'd0, 0, 0, '0);
      idle(0); @(negedge clk);
      chk("R2 num0", crd, 32'h8000_0000);
      drive(1, 1, 2'd2, 32'd31, 0, 0, '0);
      idle(0); @(negedge clk);
      chk("R2 num31", crd, 32'h8000_0001);
      // R3: upper data bits ignored, existing bits kept
      drive(1, 1, 2'd2, 32'hFFFF_FF25, 0, 0, '0);
      idle(0); @(negedge clk);
      chk("R3 accumulate", crd, 32'h8400_0001);
      // R4: bus read returns pending
      drive(1, 0, 2'd2, '0, 0, 0, '0);
      idle(0); @(negedge clk);
      chk("R4 read data", rd, 32'h8400_0001);
      // R5: bad sizes error and change nothing
      for (int s = 0; s < 4; s++) begin
         if (s != 2) begin
            drive(1, 1, 2'(s), 32'd10, 0, 0, '0);
            idle(0); @(negedge clk);
            chk("R5 bad size err", W'(rerr), 1);
            chk("R5 pend unchanged", crd, 32'h8400_0001);
         end
      end
      // R7 / R8: enable bit 26, irq one cycle after mask load
      drive(0, 0, 2'd2, '0, 1, 1, 32'h0400_0000);
      idle(1); @(negedge clk);
      chk("R7 mask", crd, 32'h0400_0000);
      chk("R8 irq delayed", W'(irq), 0);
      idle(1); @(negedge clk);
      chk("R8 irq up", W'(irq), 1);
      // R6: clear bit 26 and bit 0, MSB stays
      drive(0, 0, 2'd2, '0, 1, 0, 32'h0400_0001);
      idle(0); @(negedge clk);
      chk("R6 clear", crd, 32'h8000_0000);
      idle(0); @(negedge clk);
      chk("R8 irq down", W'(irq), 0);
      // R9: set and clear of bit 26 in the same cycle
      drive(1, 1, 2'd2, 32'd5, 1, 0, 32'h8400_0000);
      idle(0); @(negedge clk);
      chk("R9 set wins", crd, 32'h0400_0000);
      // mixed pattern sweep compared by the model
      for (int i = 0; i < 40; i++) begin
         drive(1'(i % 3 != 0), 1'(i % 2), 2'((i * 7) % 4), W'(i * 13),
               1'(i % 5 == 0), 1'(i % 4 == 1), W'(32'h1357_9BDF * i));
      end
      idle(0); idle(1);
      summary();
   end
endmodule